// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is a full-duplex synchronous serial engine that can act as the clock-driving master or as a slave that follows an external clock. A single 16-bit shift register carries one character of 1 to 16 bits. It sends bits out from its top and takes bits in at its bottom, so each character is exchanged in both directions at once. Software writes a parallel word into a transmit holding register. When the character is finished, the received word appears in a receive register.

Configuration arrives as plain level inputs: a length code, clock idle level, clock phase, master/slave choice, output enable, two interrupt enables, a run bit that doubles as a soft reset, and a 7-bit rate divisor. In master mode the engine produces the serial clock from the system clock. In slave mode it resynchronises the external clock and select to the system clock and detects edges on the synchronised copies. Three sticky status flags and one combined interrupt output report progress.

Top module: `spi_engine`

## Requirements
- R1: A character is `cfg_len_code + 1` bits long: code 0 moves one bit and code 15 moves sixteen.
- R2: The transmit word is taken left-justified: bit 15 of `tx_word` leaves first, followed by bits 14, 13, and so on, until `cfg_len_code + 1` bits have been sent.
- R3: At completion `rx_word` holds the received bits right-justified, with the first bit received in the highest of those positions. The bits above them keep what the shift register held, which is the unsent remainder of the transmit word: `rx_word = (tx_word << n) | received_bits` for an n-bit character (n < 16).
- R4: In master mode the serial clock period is `cfg_div + 1` system clocks when `cfg_div` is 3 to 127. It is 4 system clocks when `cfg_div` is 0, 1 or 2.
- R5: `sck_o` rests at `cfg_cpol` while no master character is in progress. The first clock edge of a character moves it away from that level.
- R6: With `cfg_cpha` = 0 the input is sampled on the first (leading) edge of each bit and the output changes on the trailing edge. With `cfg_cpha` = 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R7: While `cfg_talk` is 0, `sdo` is high impedance.
- R8: While `cfg_run` is 0, `st_done`, `st_ovr` and `st_txfull` read 0, and they remain 0 one cycle after `cfg_run` returns to 1.
- R9: `st_done` sets when a character completes and clears on a cycle with `rx_rd` high. `irq` reflects it only while `cfg_done_ie` is 1.
- R10: `st_ovr` sets when a character completes while `st_done` is still set and no read is occurring. It survives `rx_rd` and clears only on a cycle with `ovr_clr` high. `irq` reflects it only while `cfg_ovr_ie` is 1.
- R11: `st_txfull` sets one cycle after a `tx_wr` pulse and clears when the held word is loaded into the shift register.
- R12: In slave mode `cfg_div` has no effect. A character is loaded on the falling edge of `ss_n_i`, and the bits follow the edges of `sck_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_run | input | 1 | 1 = operate, 0 = hold engine idle and flags cleared |
| cfg_len_code | input | 4 | Character length minus one |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_talk | input | 1 | 1 = drive sdo, 0 = sdo high impedance |
| cfg_done_ie | input | 1 | Completion interrupt enable |
| cfg_ovr_ie | input | 1 | Overrun interrupt enable |
| cfg_div | input | 7 | Master rate divisor |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_word | input | 16 | Transmit data, left-justified |
| rx_rd | input | 1 | Receive read strobe, clears completion flag |
| rx_word | output | 16 | Received data, right-justified |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| st_done | output | 1 | Completion flag |
| st_ovr | output | 1 | Overrun flag |
| st_txfull | output | 1 | Transmit holding register occupied |
| irq | output | 1 | Combined enabled interrupt |
| sck_o | output | 1 | Master serial clock |
| sck_i | input | 1 | Slave serial clock input |
| ss_n_i | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, tri-stated when disabled |

## Verification
The bench loops `sdo` back into `sdi` across random lengths, phases, idle levels and divisors. It then expects the word rotated left by the character length. An engine that counts one bit too many or too few, or that clears the upper bits, gives a visibly wrong word. The rate is measured at divisors 0, 2, 3, 9 and 127. A divider that applies the low-range floor wrongly, or is off by one, gives the wrong period. In slave mode the bench drives its own clock with the divisor at 127 and checks each transmitted bit and the received word in both phases, so a swapped sample/shift edge corrupts the data. Flag tests complete two characters without a read, then check that a read clears only the completion flag, that only the write-one strobe clears overrun, that each interrupt enable gates its flag, and that the run bit clears everything.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int SPI_DATA_W    = 16;
    localparam int SPI_LEN_W     = 4;
    localparam int SPI_DIV_W     = 7;
    localparam int SPI_CNT_W     = SPI_DIV_W + 1;
    localparam int SPI_IDX_W     = SPI_LEN_W + 1;
    localparam int SPI_DIV_FLOOR = 3;
    localparam int SPI_MIN_PER   = 4;

    typedef struct packed {
        logic [SPI_LEN_W-1:0] len_code;
        logic                 cpol;
        logic                 cpha;
        logic                 master;
        logic [SPI_DIV_W-1:0] div;
    } spi_cfg_t;

    typedef struct packed {
        logic done;
        logic ovr;
        logic txfull;
    } spi_flags_t;

    // serial clock period in system clocks for a given divisor
    function automatic logic [SPI_CNT_W-1:0] baud_period(input logic [SPI_DIV_W-1:0] d);
        if (int'(d) < SPI_DIV_FLOOR)
            return SPI_CNT_W'(SPI_MIN_PER);
        else
            return {1'b0, d} + SPI_CNT_W'(1);
    endfunction

    // index of the final clock edge of a character (2*len - 1)
    function automatic logic [SPI_IDX_W-1:0] final_edge(input logic [SPI_LEN_W-1:0] code);
        return {code, 1'b1};
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= {STAGES{RST_VAL[b]}};
            else
                chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_eng_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [SPI_DIV_W-1:0] div,
    output logic                 half_tick
);
    logic [SPI_CNT_W-1:0] cnt;
    logic [SPI_CNT_W-1:0] period;
    logic [SPI_CNT_W-1:0] half;
    logic                 at_end;
    logic                 at_mid;

    assign period = baud_period(div);
    assign half   = period >> 1;
    assign at_end = (cnt >= period - SPI_CNT_W'(1));
    assign at_mid = (cnt == half - SPI_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + SPI_CNT_W'(1);
    end

    assign half_tick = en && (at_end || at_mid);

    // R4: the two half-period ticks of one period never fall in adjacent cycles
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        half_tick |=> !half_tick)
        else $error("a_r4_tick_spacing");
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_eng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  spi_cfg_t              cfg,
    input  logic                  half_tick,
    input  logic                  sck_s,
    input  logic                  ss_n_s,
    input  logic                  sdi,
    input  logic [SPI_DATA_W-1:0] tx_buf,
    input  logic                  tx_full,
    output logic                  load,
    output logic                  done,
    output logic [SPI_DATA_W-1:0] rx_word,
    output logic                  out_bit,
    output logic                  sck_o
);
    logic [SPI_DATA_W-1:0] sreg;
    logic [SPI_DATA_W-1:0] shifted;
    logic [SPI_IDX_W-1:0]  edge_idx;
    logic                  busy;
    logic                  rx_bit;
    logic                  sck_q;
    logic                  sck_d;
    logic                  ss_d;

    logic edge_ev, lead, sample_now, shift_now, last_edge;
    logic m_start, s_start, ss_fall;

    assign ss_fall    = ss_d && !ss_n_s;
    assign m_start    = cfg.master && !busy && tx_full && half_tick;
    assign s_start    = !cfg.master && ss_fall;
    assign edge_ev    = busy && (cfg.master ? half_tick
                                            : (!ss_n_s && (sck_s != sck_d)));
    assign lead       = !edge_idx[0];
    assign sample_now = edge_ev && (lead ^ cfg.cpha);
    assign shift_now  = edge_ev && !(lead ^ cfg.cpha) && !(lead && edge_idx == '0);
    assign last_edge  = edge_ev && (edge_idx == final_edge(cfg.len_code));
    assign shifted    = {sreg[SPI_DATA_W-2:0], (cfg.cpha ? sdi : rx_bit)};

    assign done    = run && last_edge;
    assign load    = run && (m_start || s_start || (last_edge && !cfg.master && !ss_n_s));
    assign out_bit = sreg[SPI_DATA_W-1];
    assign sck_o   = (cfg.master && busy) ? sck_q : cfg.cpol;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_n_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg     <= '0;
            rx_word  <= '0;
            edge_idx <= '0;
            busy     <= 1'b0;
            rx_bit   <= 1'b0;
            sck_q    <= 1'b0;
        end else if (!run) begin
            edge_idx <= '0;
            busy     <= 1'b0;
            sck_q    <= cfg.cpol;
        end else if (m_start || s_start) begin
            sreg     <= tx_buf;
            edge_idx <= '0;
            busy     <= 1'b1;
            sck_q    <= cfg.cpol;
        end else if (!cfg.master && ss_n_s) begin
            busy     <= 1'b0;
            edge_idx <= '0;
        end else if (edge_ev) begin
            sck_q <= ~sck_q;
            if (sample_now)
                rx_bit <= sdi;
            if (last_edge) begin
                rx_word  <= shifted;
                edge_idx <= '0;
                if (cfg.master) begin
                    sreg <= shifted;
                    busy <= 1'b0;
                end else begin
                    sreg <= tx_buf;
                end
            end else begin
                edge_idx <= edge_idx + SPI_IDX_W'(1);
                if (shift_now)
                    sreg <= {sreg[SPI_DATA_W-2:0], rx_bit};
            end
        end
    end

    // R1: the edge counter never passes the last edge of the configured length
    a_r1_edge_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (edge_idx <= final_edge(cfg.len_code)))
        else $error("a_r1_edge_bound");

    // R5: before the first edge of a master character the clock sits at its idle level
    a_r5_clock_home: assert property (@(posedge clk) disable iff (rst)
        (run && cfg.master && busy && edge_idx == '0) |-> (sck_q == cfg.cpol))
        else $error("a_r5_clock_home");
endmodule

// File: rtl/spi_flags.sv
module spi_flags
    import spi_eng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  tx_wr,
    input  logic [SPI_DATA_W-1:0] tx_word,
    input  logic                  load,
    input  logic                  done,
    input  logic                  rx_rd,
    input  logic                  ovr_clr,
    input  logic                  done_ie,
    input  logic                  ovr_ie,
    output logic [SPI_DATA_W-1:0] tx_buf,
    output spi_flags_t            flags,
    output logic                  irq
);
    always_ff @(posedge clk) begin
        if (rst)
            tx_buf <= '0;
        else if (tx_wr)
            tx_buf <= tx_word;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            flags <= '0;
        end else begin
            if (tx_wr)
                flags.txfull <= 1'b1;
            else if (load)
                flags.txfull <= 1'b0;

            if (done)
                flags.done <= 1'b1;
            else if (rx_rd)
                flags.done <= 1'b0;

            if (done && flags.done && !rx_rd)
                flags.ovr <= 1'b1;
            else if (ovr_clr)
                flags.ovr <= 1'b0;
        end
    end

    assign irq = (flags.done && done_ie) || (flags.ovr && ovr_ie);

    // R9: a read with no completion in the same cycle leaves the flag clear
    a_r9_done_clear: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !done) |=> !flags.done)
        else $error("a_r9_done_clear");

    // R10: overrun stays set until its clear strobe
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (run && flags.ovr && !ovr_clr) |=> flags.ovr)
        else $error("a_r10_ovr_sticky");

    // R11: the full flag only rises after a write strobe
    a_r11_txfull_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.txfull) |-> $past(tx_wr))
        else $error("a_r11_txfull_rise");

    // R8: soft reset leaves no flag standing
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> (flags == '0))
        else $error("a_r8_soft_clear");
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_eng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_run,
    input  logic [SPI_LEN_W-1:0]  cfg_len_code,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic                  cfg_master,
    input  logic                  cfg_talk,
    input  logic                  cfg_done_ie,
    input  logic                  cfg_ovr_ie,
    input  logic [SPI_DIV_W-1:0]  cfg_div,
    input  logic                  tx_wr,
    input  logic [SPI_DATA_W-1:0] tx_word,
    input  logic                  rx_rd,
    output logic [SPI_DATA_W-1:0] rx_word,
    input  logic                  ovr_clr,
    output logic                  st_done,
    output logic                  st_ovr,
    output logic                  st_txfull,
    output logic                  irq,
    output logic                  sck_o,
    input  logic                  sck_i,
    input  logic                  ss_n_i,
    input  logic                  sdi,
    output logic                  sdo
);
    spi_cfg_t              cfg;
    spi_flags_t            flags;
    logic [1:0]            pins_s;
    logic                  half_tick;
    logic                  load;
    logic                  done;
    logic                  out_bit;
    logic [SPI_DATA_W-1:0] tx_buf;

    assign cfg.len_code = cfg_len_code;
    assign cfg.cpol     = cfg_cpol;
    assign cfg.cpha     = cfg_cpha;
    assign cfg.master   = cfg_master;
    assign cfg.div      = cfg_div;

    spi_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_i, sck_i}),
        .q   (pins_s)
    );

    spi_baud_gen u_baud (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_run && cfg_master),
        .div       (cfg_div),
        .half_tick (half_tick)
    );

    spi_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg_run),
        .cfg       (cfg),
        .half_tick (half_tick),
        .sck_s     (pins_s[0]),
        .ss_n_s    (pins_s[1]),
        .sdi       (sdi),
        .tx_buf    (tx_buf),
        .tx_full   (flags.txfull),
        .load      (load),
        .done      (done),
        .rx_word   (rx_word),
        .out_bit   (out_bit),
        .sck_o     (sck_o)
    );

    spi_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg_run),
        .tx_wr   (tx_wr),
        .tx_word (tx_word),
        .load    (load),
        .done    (done),
        .rx_rd   (rx_rd),
        .ovr_clr (ovr_clr),
        .done_ie (cfg_done_ie),
        .ovr_ie  (cfg_ovr_ie),
        .tx_buf  (tx_buf),
        .flags   (flags),
        .irq     (irq)
    );

    assign st_done   = flags.done;
    assign st_ovr    = flags.ovr;
    assign st_txfull = flags.txfull;
    assign sdo       = cfg_talk ? out_bit : 1'bz;
endmodule

// File: tb/spi_engine_test.sv
module spi_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_run = 1'b0;
    logic [3:0]  cfg_len_code = 4'd7;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_master = 1'b1;
    logic        cfg_talk = 1'b1;
    logic        cfg_done_ie = 1'b0;
    logic        cfg_ovr_ie = 1'b0;
    logic [6:0]  cfg_div = 7'd0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_word = '0;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_word;
    logic        ovr_clr = 1'b0;
    logic        st_done, st_ovr, st_txfull, irq, sck_o;
    logic        sck_i = 1'b0;
    logic        ss_n_i = 1'b1;
    logic        sdi;
    logic        sdo;
    logic        loop_en = 1'b1;
    logic        sdi_drv = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    assign sdi = loop_en ? sdo : sdi_drv;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_engine uut (
        .clk(clk), .rst(rst), .cfg_run(cfg_run), .cfg_len_code(cfg_len_code),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_master(cfg_master),
        .cfg_talk(cfg_talk), .cfg_done_ie(cfg_done_ie), .cfg_ovr_ie(cfg_ovr_ie),
        .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_word(tx_word), .rx_rd(rx_rd),
        .rx_word(rx_word), .ovr_clr(ovr_clr), .st_done(st_done), .st_ovr(st_ovr),
        .st_txfull(st_txfull), .irq(irq), .sck_o(sck_o), .sck_i(sck_i),
        .ss_n_i(ss_n_i), .sdi(sdi), .sdo(sdo)
    );

    function automatic logic [15:0] rotl(input logic [15:0] v, input int n);
        if (n >= 16) return v;
        return (v << n) | (v >> (16 - n));
    endfunction

    function automatic int exp_period(input int d);
        return (d < 3) ? 4 : d + 1;
    endfunction

    function automatic logic [15:0] slave_rx(input logic [15:0] tx, input logic [15:0] bits, input int n);
        logic [31:0] m;
        if (n >= 16) return bits;
        m = (32'h1 << n) - 32'h1;
        return 16'(((32'(tx) << n) | (32'(bits) & m)));
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_tx(input logic [15:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_word = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 6000 && !st_done; g++) @(negedge clk);
    endtask

    task automatic wait_ovr();
        for (int g = 0; g < 6000 && !st_ovr; g++) @(negedge clk);
    endtask

    task automatic measure_period(input int d);
        int t1, t2;
        logic prev;
        cfg_div = 7'(d); cfg_len_code = 4'd1; cfg_cpol = 1'b0;
        t1 = -1; t2 = -1;
        write_tx(16'hA5A5);
        prev = sck_o;
        for (int g = 0; g < 2000 && t2 < 0; g++) begin
            @(negedge clk);
            if (!prev && sck_o) begin
                if (t1 < 0) t1 = cyc; else t2 = cyc;
            end
            prev = sck_o;
        end
        check((t2 - t1) == exp_period(d), "R4 serial clock period", 32'(t2 - t1), 32'(exp_period(d)));
        wait_done();
        read_rx();
    endtask

    task automatic slave_xfer(input int n, input logic ph, input logic pol,
                              input logic [15:0] tx, input logic [15:0] bits);
        logic [15:0] seen;
        seen = '0;
        cfg_master = 1'b0; cfg_cpha = ph; cfg_cpol = pol; cfg_div = 7'd127;
        cfg_len_code = 4'(n - 1);
        loop_en = 1'b0; sck_i = pol;
        write_tx(tx);
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (!ph) begin
                sdi_drv = bits[n-1-i];
                repeat (8) @(negedge clk);
                sck_i = ~pol;
                seen = {seen[14:0], sdo};
                repeat (8) @(negedge clk);
                sck_i = pol;
            end else begin
                sck_i = ~pol;
                sdi_drv = bits[n-1-i];
                repeat (8) @(negedge clk);
                sck_i = pol;
                seen = {seen[14:0], sdo};
                repeat (8) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        check(st_done == 1'b1, "R12 slave completion", 32'(st_done), 32'd1);
        check(rx_word == slave_rx(tx, bits, n), "R3 R6 slave receive word",
              32'(rx_word), 32'(slave_rx(tx, bits, n)));
        check(seen == (tx >> (16 - n)), "R2 slave transmit order MSB first",
              32'(seen), 32'(tx >> (16 - n)));
        ss_n_i = 1'b1;
        read_rx();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, w;
        int n, d;
        void'($urandom(32'd4217));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R8 also covers run=0
        check({st_done, st_ovr, st_txfull, irq} == 4'b0, "R8 reset flags", 32'({st_done, st_ovr, st_txfull, irq}), 32'd0);
        check(sck_o == 1'b0, "R5 idle clock after reset", 32'(sck_o), 32'd0);
        cfg_run = 1'b1;
        @(negedge clk);

        // R11 full flag around a load, R1 sixteen-bit character
        cfg_len_code = 4'd15; cfg_div = 7'd5;
        write_tx(16'hC3A1);
        check(st_txfull == 1'b1, "R11 full after write", 32'(st_txfull), 32'd1);
        wait_done();
        check(st_txfull == 1'b0, "R11 full cleared by load", 32'(st_txfull), 32'd0);
        check(rx_word == 16'hC3A1, "R1 sixteen-bit loopback", 32'(rx_word), 32'hC3A1);
        read_rx();
        check(st_done == 1'b0, "R9 read clears completion", 32'(st_done), 32'd0);

        // R1 single-bit character
        cfg_len_code = 4'd0;
        write_tx(16'h8001);
        wait_done();
        check(rx_word == rotl(16'h8001, 1), "R1 one-bit character", 32'(rx_word), 32'(rotl(16'h8001, 1)));
        read_rx();

        // R4 divisor ranges
        measure_period(0);
        measure_period(2);
        measure_period(3);
        measure_period(9);
        measure_period(127);

        // R5 idle level with high polarity
        cfg_cpol = 1'b1; cfg_div = 7'd3;
        repeat (3) @(negedge clk);
        check(sck_o == 1'b1, "R5 idle level high", 32'(sck_o), 32'd1);

        // R7 tri-state, R3 upper bits kept
        cfg_talk = 1'b0; loop_en = 1'b0; sdi_drv = 1'b1; cfg_len_code = 4'd7; cfg_cpol = 1'b0;
        write_tx(16'h5A3C);
        check(sdo === 1'bz, "R7 output released", 32'(sdo), 32'd0);
        wait_done();
        check(rx_word == 16'h3CFF, "R3 right-justified receive", 32'(rx_word), 32'h3CFF);
        read_rx();
        cfg_talk = 1'b1; loop_en = 1'b1;

        // R9 R10 overrun and interrupt gating
        cfg_len_code = 4'd3;
        write_tx(16'h1234);
        wait_done();
        check(irq == 1'b0, "R9 completion masked", 32'(irq), 32'd0);
        cfg_done_ie = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R9 completion interrupt", 32'(irq), 32'd1);
        cfg_done_ie = 1'b0;
        write_tx(16'hB000);
        wait_ovr();
        check(st_ovr == 1'b1, "R10 overrun on unread word", 32'(st_ovr), 32'd1);
        check(irq == 1'b0, "R10 overrun masked", 32'(irq), 32'd0);
        cfg_ovr_ie = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R10 overrun interrupt", 32'(irq), 32'd1);
        read_rx();
        check(st_done == 1'b0 && st_ovr == 1'b1, "R10 read leaves overrun", 32'({st_done, st_ovr}), 32'b01);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        check(st_ovr == 1'b0, "R10 write-one clear", 32'(st_ovr), 32'd0);
        cfg_ovr_ie = 1'b0;

        // R8 soft reset
        write_tx(16'hFFFF);
        wait_done();
        write_tx(16'h0F0F);
        cfg_run = 1'b0;
        @(negedge clk);
        check({st_done, st_ovr, st_txfull} == 3'b0, "R8 run low clears flags", 32'({st_done, st_ovr, st_txfull}), 32'd0);
        cfg_run = 1'b1;
        @(negedge clk);
        check({st_done, st_ovr, st_txfull} == 3'b0, "R8 flags stay clear", 32'({st_done, st_ovr, st_txfull}), 32'd0);

        // R6 R1 R3 random master loopback
        for (int k = 0; k < 24; k++) begin
            n = int'($urandom_range(1, 16));
            d = int'($urandom_range(0, 9));
            v = 16'($urandom);
            cfg_len_code = 4'(n - 1); cfg_div = 7'(d);
            cfg_cpha = 1'($urandom); cfg_cpol = 1'($urandom);
            @(negedge clk);
            write_tx(v);
            wait_done();
            w = rotl(v, n);
            check(rx_word == w, "R6 R1 R3 loopback", 32'(rx_word), 32'(w));
            read_rx();
        end

        // R12 R2 R6 slave mode in both phases
        slave_xfer(8, 1'b0, 1'b0, 16'hB700, 16'h005D);
        slave_xfer(5, 1'b1, 1'b1, 16'h9800, 16'h0013);
        slave_xfer(16, 1'b1, 1'b0, 16'h6E29, 16'hD1C4);

        ended = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule